// File: doc/BRIEF.md
# Completion Arbiter with Early Tag Broadcast

This block sits at the back end of an out-of-order core, where three functional units finish instructions: the memory unit, the integer unit and the multiplier. Each cycle it lets exactly one finished instruction publish its result. Any other unit that is also done waits and keeps its result. The priority is fixed: memory first, then integer, then multiply.

The winning destination tag goes out in the same cycle the arbiter picks it. The matching value appears on a separate registered bus one cycle later. Issue-queue entries and the decode stage watch the tag bus, so a dependent instruction can wake up and issue on the cycle after its producer.

The block also contains the two fixed-latency units. The integer unit takes one cycle; it adds, subtracts, ANDs, and produces the equality outcome used to resolve a branch. The multiplier is a four-stage pipeline. When it loses arbitration, the whole pipeline freezes. The memory unit's completion arrives on a plain valid/ready port.

Top module: `cbx_writeback_arb`

## Requirements
- R1: At most one completion is published per cycle. When `tag_valid` is high, `tag_src` names its unit: 0 memory, 1 integer, 2 multiply.
- R2: Priority is fixed with memory highest, then integer, then multiply. A memory completion is published in the same cycle `mem_valid` is high, and `mem_ready` stays high.
- R3: `res_valid`, `res_tag` and `res_data` carry, one cycle later, the result whose tag was on `tag_id` in the previous cycle. `res_valid` is low in any cycle that follows a cycle without a tag.
- R4: An integer operation accepted at a clock edge has its tag published in the cycle right after that edge when nothing of higher priority competes. Operations issued on consecutive cycles are published on consecutive cycles.
- R5: Integer op encoding: 0 gives a+b, 1 gives a-b, 2 gives a&b, 3 gives 1 if a==b and 0 otherwise. All results are truncated to the data width.
- R6: An integer result that loses arbitration is held unchanged, and `int_ready` is low until it wins.
- R7: A multiply accepted at a clock edge has its tag published four cycles later when nothing of higher priority competes.
- R8: The multiply result is the low data-width bits of the product of the two operands.
- R9: While the last multiply stage holds a result that loses arbitration, the multiply pipeline does not advance and `mul_ready` is low.
- R10: After reset, `tag_valid` and `res_valid` are low and all three ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_valid | input | 1 | Memory unit has a finished result |
| mem_ready | output | 1 | Memory completion taken this cycle |
| mem_tag | input | TW | Tag of the memory result |
| mem_data | input | DW | Memory result value |
| int_valid | input | 1 | Integer operation offered |
| int_ready | output | 1 | Integer unit accepts at next edge |
| int_op | input | 2 | Integer operation select |
| int_a | input | DW | Integer operand A |
| int_b | input | DW | Integer operand B |
| int_tag | input | TW | Integer destination tag |
| mul_valid | input | 1 | Multiply offered |
| mul_ready | output | 1 | Multiplier accepts at next edge |
| mul_a | input | DW | Multiply operand A |
| mul_b | input | DW | Multiply operand B |
| mul_tag | input | TW | Multiply destination tag |
| tag_valid | output | 1 | A tag is being published |
| tag_id | output | TW | Published tag |
| tag_src | output | 2 | Unit that owns the published tag |
| res_valid | output | 1 | Value bus valid |
| res_tag | output | TW | Tag of the value on the bus |
| res_data | output | DW | Published value |

## Verification
The hardest situation to reach is all three units finishing in the same cycle. The multiply must be issued three cycles before the integer operation, and the memory completion must arrive on the cycle after that. The bench generates this timing for every subset of the three units and for every integer operation. It then checks the order of publication, the one-cycle gap between tag and value, and the ready outputs of the losing units. A separate sequence holds memory completions across several cycles while two multiplies are in flight, which shows the frozen pipeline releasing its results in order.

// File: rtl/cbx_pkg.sv
// Shared definitions for the completion arbiter.
// Assumes: index order of the source codes is the arbitration priority.
package cbx_pkg;

    typedef enum logic [1:0] {
        SRC_MEM = 2'd0,
        SRC_INT = 2'd1,
        SRC_MUL = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        IOP_ADD = 2'd0,
        IOP_SUB = 2'd1,
        IOP_AND = 2'd2,
        IOP_EQ  = 2'd3
    } iop_e;

    localparam int NUM_SRC = 3;

endpackage

// File: rtl/cbx_prio_pick.sv
// Fixed-priority one-hot picker.
// Does: grants the lowest-index asserted request.
// Assumes: index 0 is the highest priority.
module cbx_prio_pick #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);

    // Grant bit 0 whenever it requests.
    assign gnt[0] = req[0];

    generate
        for (genvar i = 1; i < N; i++) begin : g_bit
            // Grant bit i only if no higher-priority bit requests.
            assign gnt[i] = req[i] & ~(|req[i-1:0]);
        end
    endgenerate

endmodule

// File: rtl/cbx_int_stage.sv
// Single-cycle integer unit with a holding output register.
// Does: computes at acceptance and presents the result as a completion
// candidate in the next cycle; keeps it until it wins arbitration.
// Assumes: win is only asserted while out_valid is high.
module cbx_int_stage
    import cbx_pkg::*;
#(
    parameter int DW = 16,
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [1:0]    in_op,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_b,
    input  logic [TW-1:0] in_tag,
    input  logic          win,
    output logic          out_valid,
    output logic [TW-1:0] out_tag,
    output logic [DW-1:0] out_data
);

    logic [DW-1:0] calc;
    logic          hold_v;
    logic [TW-1:0] hold_tag;
    logic [DW-1:0] hold_data;

    // Compute the selected operation.
    always_comb begin
        unique case (iop_e'(in_op))
            IOP_ADD: calc = in_a + in_b;
            IOP_SUB: calc = in_a - in_b;
            IOP_AND: calc = in_a & in_b;
            IOP_EQ:  calc = (in_a == in_b) ? DW'(1) : '0;
            default: calc = '0;
        endcase
    end

    // Accept when empty or when the held result leaves this cycle.
    assign in_ready = !hold_v || win;

    // Capture a new result or release the held one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v    <= 1'b0;
            hold_tag  <= '0;
            hold_data <= '0;
        end else if (in_valid && in_ready) begin
            hold_v    <= 1'b1;
            hold_tag  <= in_tag;
            hold_data <= calc;
        end else if (win) begin
            hold_v    <= 1'b0;
        end
    end

    assign out_valid = hold_v;
    assign out_tag   = hold_tag;
    assign out_data  = hold_data;

endmodule

// File: rtl/cbx_mul_pipe.sv
// Multiply pipeline of STAGES registers.
// Does: product computed on entry, carried through the stages; the last
// stage is the completion candidate.
// Assumes: the whole pipe stalls while the last stage holds a losing result.
module cbx_mul_pipe #(
    parameter int DW     = 16,
    parameter int TW     = 5,
    parameter int STAGES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_b,
    input  logic [TW-1:0] in_tag,
    input  logic          win,
    output logic          out_valid,
    output logic [TW-1:0] out_tag,
    output logic [DW-1:0] out_data
);

    localparam int PW = 2 * DW;

    logic          st_v   [STAGES];
    logic [TW-1:0] st_tag [STAGES];
    logic [DW-1:0] st_prd [STAGES];
    logic [PW-1:0] full;
    logic          advance;

    // Full-width product of the incoming operands.
    assign full = PW'(in_a) * PW'(in_b);

    // The pipe moves only if the last stage is empty or leaving.
    assign advance  = !st_v[STAGES-1] || win;
    assign in_ready = advance;

    // Shift every stage forward on advance; freeze otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                st_v[s]   <= 1'b0;
                st_tag[s] <= '0;
                st_prd[s] <= '0;
            end
        end else if (advance) begin
            st_v[0]   <= in_valid;
            st_tag[0] <= in_tag;
            st_prd[0] <= full[DW-1:0];
            for (int s = 1; s < STAGES; s++) begin
                st_v[s]   <= st_v[s-1];
                st_tag[s] <= st_tag[s-1];
                st_prd[s] <= st_prd[s-1];
            end
        end
    end

    assign out_valid = st_v[STAGES-1];
    assign out_tag   = st_tag[STAGES-1];
    assign out_data  = st_prd[STAGES-1];

endmodule

// File: rtl/cbx_writeback_arb.sv
// Completion arbiter with early tag broadcast.
// Does: picks one of memory/integer/multiply completions per cycle by fixed
// priority, publishes its tag at once and its value one cycle later.
// Assumes: the memory unit presents a finished result on mem_valid and
// keeps it until mem_ready; it always wins, so mem_ready stays high.
module cbx_writeback_arb
    import cbx_pkg::*;
#(
    parameter int DW         = 16,
    parameter int TW         = 5,
    parameter int MUL_STAGES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mem_valid,
    output logic          mem_ready,
    input  logic [TW-1:0] mem_tag,
    input  logic [DW-1:0] mem_data,
    input  logic          int_valid,
    output logic          int_ready,
    input  logic [1:0]    int_op,
    input  logic [DW-1:0] int_a,
    input  logic [DW-1:0] int_b,
    input  logic [TW-1:0] int_tag,
    input  logic          mul_valid,
    output logic          mul_ready,
    input  logic [DW-1:0] mul_a,
    input  logic [DW-1:0] mul_b,
    input  logic [TW-1:0] mul_tag,
    output logic          tag_valid,
    output logic [TW-1:0] tag_id,
    output logic [1:0]    tag_src,
    output logic          res_valid,
    output logic [TW-1:0] res_tag,
    output logic [DW-1:0] res_data
);

    logic [NUM_SRC-1:0] req;
    logic [NUM_SRC-1:0] gnt;
    logic               int_cand;
    logic               int_win;
    logic [TW-1:0]      int_cand_tag;
    logic [DW-1:0]      int_cand_data;
    logic               mul_cand;
    logic               mul_win;
    logic [TW-1:0]      mul_cand_tag;
    logic [DW-1:0]      mul_cand_data;
    logic [DW-1:0]      sel_data;
    logic               val_q;
    logic [TW-1:0]      val_tag_q;
    logic [DW-1:0]      val_data_q;

    cbx_int_stage #(.DW(DW), .TW(TW)) u_int (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (int_valid),
        .in_ready (int_ready),
        .in_op    (int_op),
        .in_a     (int_a),
        .in_b     (int_b),
        .in_tag   (int_tag),
        .win      (int_win),
        .out_valid(int_cand),
        .out_tag  (int_cand_tag),
        .out_data (int_cand_data)
    );

    cbx_mul_pipe #(.DW(DW), .TW(TW), .STAGES(MUL_STAGES)) u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (mul_valid),
        .in_ready (mul_ready),
        .in_a     (mul_a),
        .in_b     (mul_b),
        .in_tag   (mul_tag),
        .win      (mul_win),
        .out_valid(mul_cand),
        .out_tag  (mul_cand_tag),
        .out_data (mul_cand_data)
    );

    // Request vector in priority order.
    assign req = {mul_cand, int_cand, mem_valid};

    cbx_prio_pick #(.N(NUM_SRC)) u_pick (
        .req(req),
        .gnt(gnt)
    );

    assign int_win   = gnt[SRC_INT];
    assign mul_win   = gnt[SRC_MUL];
    assign mem_ready = gnt[SRC_MEM] || !mem_valid;

    // Select tag, source and value of the winner.
    always_comb begin
        tag_valid = |req;
        tag_id    = '0;
        tag_src   = SRC_MEM;
        sel_data  = '0;
        if (gnt[SRC_MEM]) begin
            tag_id   = mem_tag;
            tag_src  = SRC_MEM;
            sel_data = mem_data;
        end else if (gnt[SRC_INT]) begin
            tag_id   = int_cand_tag;
            tag_src  = SRC_INT;
            sel_data = int_cand_data;
        end else if (gnt[SRC_MUL]) begin
            tag_id   = mul_cand_tag;
            tag_src  = SRC_MUL;
            sel_data = mul_cand_data;
        end
    end

    // Register the value bus one cycle behind the tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q      <= 1'b0;
            val_tag_q  <= '0;
            val_data_q <= '0;
        end else begin
            val_q      <= tag_valid;
            val_tag_q  <= tag_id;
            val_data_q <= sel_data;
        end
    end

    assign res_valid = val_q;
    assign res_tag   = val_tag_q;
    assign res_data  = val_data_q;

endmodule

// File: rtl/cbx_checks.sv
// Property checker for the completion arbiter, bound to the top module.
// Assumes: it observes the grant vector and each unit's candidate outputs.
module cbx_checks #(
    parameter int TW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_valid,
    input logic          tag_valid,
    input logic [1:0]    tag_src,
    input logic [TW-1:0] tag_id,
    input logic          res_valid,
    input logic [TW-1:0] res_tag,
    input logic [2:0]    gnt,
    input logic          int_cand,
    input logic          int_win,
    input logic [TW-1:0] int_cand_tag,
    input logic          mul_cand,
    input logic          mul_win,
    input logic [TW-1:0] mul_cand_tag
);

    a_r1_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    a_r2_mem_first: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (tag_valid && tag_src == 2'd0));

    a_r3_value_follows: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid |=> (res_valid && res_tag == $past(tag_id)));

    a_r3_no_value: assert property (@(posedge clk) disable iff (!rst_n)
        !tag_valid |=> !res_valid);

    a_r6_int_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (int_cand && !int_win) |=> (int_cand && $stable(int_cand_tag)));

    a_r9_mul_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_cand && !mul_win) |=> (mul_cand && $stable(mul_cand_tag)));

endmodule

bind cbx_writeback_arb cbx_checks #(.TW(TW)) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_valid   (mem_valid),
    .tag_valid   (tag_valid),
    .tag_src     (tag_src),
    .tag_id      (tag_id),
    .res_valid   (res_valid),
    .res_tag     (res_tag),
    .gnt         (gnt),
    .int_cand    (int_cand),
    .int_win     (int_win),
    .int_cand_tag(int_cand_tag),
    .mul_cand    (mul_cand),
    .mul_win     (mul_win),
    .mul_cand_tag(mul_cand_tag)
);

// File: tb/sim_cbx_writeback_arb.sv
`timescale 1ns/1ps
module sim_cbx_writeback_arb;

    localparam int DW = 16;
    localparam int TW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          mem_valid;
    logic          mem_ready;
    logic [TW-1:0] mem_tag;
    logic [DW-1:0] mem_data;
    logic          int_valid;
    logic          int_ready;
    logic [1:0]    int_op;
    logic [DW-1:0] int_a, int_b;
    logic [TW-1:0] int_tag;
    logic          mul_valid;
    logic          mul_ready;
    logic [DW-1:0] mul_a, mul_b;
    logic [TW-1:0] mul_tag;
    logic          tag_valid;
    logic [TW-1:0] tag_id;
    logic [1:0]    tag_src;
    logic          res_valid;
    logic [TW-1:0] res_tag;
    logic [DW-1:0] res_data;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    cbx_writeback_arb u0 (
        .clk(clk), .rst_n(rst_n),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_tag(mem_tag), .mem_data(mem_data),
        .int_valid(int_valid), .int_ready(int_ready), .int_op(int_op),
        .int_a(int_a), .int_b(int_b), .int_tag(int_tag),
        .mul_valid(mul_valid), .mul_ready(mul_ready), .mul_a(mul_a), .mul_b(mul_b),
        .mul_tag(mul_tag),
        .tag_valid(tag_valid), .tag_id(tag_id), .tag_src(tag_src),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] int_model(input logic [1:0] op,
                                                input logic [DW-1:0] a, b);
        case (op)
            2'd0: return a + b;
            2'd1: return a - b;
            2'd2: return a & b;
            default: return (a == b) ? DW'(1) : DW'(0);
        endcase
    endfunction

    function automatic logic [DW-1:0] mul_model(input logic [DW-1:0] a, b);
        logic [2*DW-1:0] p;
        p = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
        return p[DW-1:0];
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    // One collision scenario: subset c of units finishing in the same cycle.
    task automatic run_combo(input int c, input logic [1:0] op);
        bit hm, hi, hu;
        logic [TW-1:0] et [3];
        logic [1:0]    es [3];
        logic [DW-1:0] ed [3];
        int n;
        logic [DW-1:0] ia, ib, ma, mb, md;
        hm = c[0]; hi = c[1]; hu = c[2];
        ia = DW'(16'h1234 + c * 97 + op * 13);
        ib = (op == 2'd3 && c[0]) ? ia : DW'(16'h0F0F + c * 31);
        ma = DW'(16'h0F00 + c * 7 + op);
        mb = DW'(16'h0123 + op * 5);
        md = DW'(16'hA500 + c * 16 + op);
        n = 0;
        if (hm) begin et[n] = TW'(3);  es[n] = 2'd0; ed[n] = md; n++; end
        if (hi) begin et[n] = TW'(9);  es[n] = 2'd1; ed[n] = int_model(op, ia, ib); n++; end
        if (hu) begin et[n] = TW'(17); es[n] = 2'd2; ed[n] = mul_model(ma, mb); n++; end
        // N0: offer the multiply (R7 timing starts here).
        tick();
        if (hu) begin mul_valid = 1'b1; mul_a = ma; mul_b = mb; mul_tag = TW'(17); end
        #1;
        if (hu) check("R9 mul_ready idle", 32'(mul_ready), 32'd1);
        tick(); mul_valid = 1'b0;
        tick();
        // N3: offer the integer op.
        tick();
        if (hi) begin int_valid = 1'b1; int_op = op; int_a = ia; int_b = ib; int_tag = TW'(9); end
        #1;
        if (hi) check("R6 int_ready idle", 32'(int_ready), 32'd1);
        // N4: all chosen units are candidates now.
        tick();
        int_valid = 1'b0;
        if (hm) begin mem_valid = 1'b1; mem_tag = TW'(3); mem_data = md; end
        #1;
        if (hm) check("R2 mem_ready", 32'(mem_ready), 32'd1);
        if (hi) check("R6 int_ready while contended", 32'(int_ready), hm ? 32'd0 : 32'd1);
        if (hu) check("R9 mul_ready while contended", 32'(mul_ready), (hm || hi) ? 32'd0 : 32'd1);
        for (int k = 0; k < n; k++) begin
            if (k > 0) begin
                tick();
                mem_valid = 1'b0;
                #1;
            end
            check("R1 tag_valid", 32'(tag_valid), 32'd1);
            check("R2 priority tag", 32'(tag_id), 32'(et[k]));
            check("R1 tag_src", 32'(tag_src), 32'(es[k]));
            if (k > 0) begin
                check("R3 res_tag", 32'(res_tag), 32'(et[k-1]));
                check(es[k-1] == 2'd1 ? "R5 int value" : (es[k-1] == 2'd2 ? "R8 mul value" : "R3 mem value"),
                      32'(res_data), 32'(ed[k-1]));
            end
        end
        tick();
        mem_valid = 1'b0;
        #1;
        check("R1 idle after drain", 32'(tag_valid), 32'd0);
        if (n > 0) begin
            check("R3 res_valid last", 32'(res_valid), 32'd1);
            check("R3 res_tag last", 32'(res_tag), 32'(et[n-1]));
            check(es[n-1] == 2'd1 ? "R5 int value" : (es[n-1] == 2'd2 ? "R8 mul value" : "R3 mem value"),
                  32'(res_data), 32'(ed[n-1]));
        end
        tick(); #1;
        check("R3 res_valid drops", 32'(res_valid), 32'd0);
        tick();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        mem_valid = 1'b0; mem_tag = '0; mem_data = '0;
        int_valid = 1'b0; int_op = '0; int_a = '0; int_b = '0; int_tag = '0;
        mul_valid = 1'b0; mul_a = '0; mul_b = '0; mul_tag = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        // R10 reset state.
        check("R10 tag_valid", 32'(tag_valid), 32'd0);
        check("R10 res_valid", 32'(res_valid), 32'd0);
        check("R10 mem_ready", 32'(mem_ready), 32'd1);
        check("R10 int_ready", 32'(int_ready), 32'd1);
        check("R10 mul_ready", 32'(mul_ready), 32'd1);

        // Sweep every subset of units and every integer operation.
        for (int c = 0; c < 8; c++)
            for (int op = 0; op < 4; op++)
                run_combo(c, 2'(op));

        // R4: integer ops on consecutive cycles publish on consecutive cycles.
        for (int k = 0; k < 6; k++) begin
            tick();
            if (k < 4) begin
                int_valid = 1'b1; int_op = 2'd0;
                int_a = DW'(100 * k); int_b = DW'(7); int_tag = TW'(k + 1);
            end else begin
                int_valid = 1'b0;
            end
            #1;
            if (k < 4) check("R4 int_ready streaming", 32'(int_ready), 32'd1);
            if (k >= 1 && k <= 4) begin
                check("R4 tag next cycle", 32'(tag_valid), 32'd1);
                check("R4 tag order", 32'(tag_id), 32'(k));
            end
            if (k >= 2) begin
                check("R4 value order", 32'(res_tag), 32'(k - 1));
                check("R5 add value", 32'(res_data), 32'(DW'(100 * (k - 2) + 7)));
            end
        end
        repeat (3) tick();

        // R9: memory completions hold off two multiplies in flight.
        for (int k = 0; k < 11; k++) begin
            tick();
            mul_valid = (k == 0 || k == 1);
            mul_a = DW'(16'h0301 + k); mul_b = DW'(16'h0207 + k); mul_tag = TW'(20 + k);
            mem_valid = (k >= 3 && k <= 6);
            mem_tag = TW'(24 + k - 3); mem_data = DW'(16'h5A00 + k);
            #1;
            if (k >= 3 && k <= 6) begin
                check("R2 mem wins over mul", 32'(tag_id), 32'(24 + k - 3));
                check("R1 src mem", 32'(tag_src), 32'd0);
            end
            if (k >= 4 && k <= 6) check("R9 mul_ready frozen", 32'(mul_ready), 32'd0);
            if (k == 7) begin
                check("R9 mul_ready released", 32'(mul_ready), 32'd1);
                check("R9 first mul tag", 32'(tag_id), 32'd20);
                check("R1 src mul", 32'(tag_src), 32'd2);
            end
            if (k == 8) begin
                check("R9 second mul tag", 32'(tag_id), 32'd21);
                check("R8 first product", 32'(res_data), 32'(mul_model(DW'(16'h0301), DW'(16'h0207))));
            end
            if (k == 9) begin
                check("R1 idle", 32'(tag_valid), 32'd0);
                check("R8 second product", 32'(res_data), 32'(mul_model(DW'(16'h0302), DW'(16'h0208))));
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule